// File: doc/BRIEF.md
# Coin Credit Accumulator FSM

This block tracks the credit built up by coins dropped into a vending mechanism. It accepts two coin kinds, worth 10 and 25 units, and moves through a fixed set of credit states: 0, 10, 20, 25, 30 and 35. The 35-unit state is the full-payment state and also the ceiling. Any coin that would push the credit past 35 leaves the machine at 35, so the block is a saturating state machine and not an open-ended adder.

Each coin is a one-cycle pulse. A synchronous clear request returns the machine to zero credit from any state. The block drives the current credit as a 3-bit code and a registered "paid" flag. The flag is high exactly while the machine sits in the 35 state. An input stage settles priority between simultaneous requests and hands the datapath a small bundle of strobes. The datapath holds the credit register and the paid register.

Top module: `coin_credit_fsm`

## Requirements
- R1: When `clearReq` is high at a rising edge, `creditCode` is 0 and `paid` is low after that edge, whatever the state and whatever the coin inputs.
- R2: When no coin and no clear are present at an edge, `creditCode` and `paid` do not change.
- R3: From credit 0, a dime moves to credit 10 and a quarter moves to credit 25.
- R4: From credit 10, a dime moves to credit 20 and a quarter moves to credit 35.
- R5: From credit 20, a dime moves to credit 30 and a quarter moves to credit 35.
- R6: From credit 25 and from credit 30, either coin moves to credit 35.
- R7: At credit 35, dimes and quarters leave the state unchanged.
- R8: When a dime and a quarter arrive in the same cycle without a clear, only the quarter is counted.
- R9: `paid` is a registered output. It is high in exactly the cycles where the credit is 35.
- R10: `creditCode` encodes credit 0, 10, 20, 25, 30 and 35 as 0, 1, 2, 3, 4 and 5, and never takes the values 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clearReq | input | 1 | Synchronous request to return to zero credit; overrides coins |
| dimeIn | input | 1 | One-cycle pulse for a 10-unit coin |
| quarterIn | input | 1 | One-cycle pulse for a 25-unit coin |
| creditCode | output | 3 | Current credit state code (see R10) |
| paid | output | 1 | High while the credit is 35 |

## Verification
The cases hardest to reach are the pairs that start from a deep state, such as 30 or 35, and see a simultaneous dime and quarter or a clear that arrives together with coins. Each of these states can only be reached by a particular sequence of earlier coins. To cover them, the bench first runs a vector table through the ordinary paths. It then steps through every state and input pair: it clears the machine, replays a fixed coin sequence that lands on the chosen state, applies one of five input patterns, and compares the result against its own transition function.

// File: rtl/coin_credit_pkg.sv
package coin_credit_pkg;

  localparam int CREDIT_W = 3;

  typedef enum logic [CREDIT_W-1:0] {
    CR_00 = 3'd0,
    CR_10 = 3'd1,
    CR_20 = 3'd2,
    CR_25 = 3'd3,
    CR_30 = 3'd4,
    CR_35 = 3'd5
  } credit_e;

  typedef struct packed {
    logic clr;
    logic addDime;
    logic addQuarter;
  } coinStrobe_t;

endpackage

// File: rtl/coin_credit_ctrl.sv
module coin_credit_ctrl
  import coin_credit_pkg::*;
(
  input  logic        clearReq,
  input  logic        dimeIn,
  input  logic        quarterIn,
  output coinStrobe_t strobes
);

  logic anyCoin;

  always_comb begin
    anyCoin            = dimeIn | quarterIn;
    strobes            = '0;
    strobes.clr        = clearReq;
    // A clear beats any coin; a quarter beats a dime in the same cycle.
    strobes.addQuarter = !clearReq && quarterIn;
    strobes.addDime    = !clearReq && anyCoin && !quarterIn;
  end

endmodule

// File: rtl/coin_credit_path.sv
module coin_credit_path
  import coin_credit_pkg::*;
(
  input  logic        clk,
  input  coinStrobe_t strobes,
  output credit_e     creditQ,
  output logic        paidQ
);

  credit_e creditNext;

  always_comb begin
    creditNext = creditQ;
    if (strobes.clr) begin
      creditNext = CR_00;
    end else if (strobes.addQuarter) begin
      unique case (creditQ)
        CR_00:   creditNext = CR_25;
        default: creditNext = CR_35;
      endcase
    end else if (strobes.addDime) begin
      unique case (creditQ)
        CR_00:   creditNext = CR_10;
        CR_10:   creditNext = CR_20;
        CR_20:   creditNext = CR_30;
        default: creditNext = CR_35;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    creditQ <= creditNext;
    paidQ   <= (creditNext == CR_35);
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk)
    strobes.clr |=> (creditQ == CR_00) && !paidQ); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (strobes.clr)
    (!strobes.addDime && !strobes.addQuarter) |=> $stable(creditQ) && $stable(paidQ)); // R2

  AST_ZERO_QUARTER: assert property (@(posedge clk) disable iff (strobes.clr)
    (creditQ == CR_00 && strobes.addQuarter) |=> creditQ == CR_25); // R3

  AST_MID_TO_TOP: assert property (@(posedge clk) disable iff (strobes.clr)
    ((creditQ == CR_25 || creditQ == CR_30) && (strobes.addDime || strobes.addQuarter))
      |=> creditQ == CR_35); // R6

  AST_TOP_STICKY: assert property (@(posedge clk) disable iff (strobes.clr)
    (creditQ == CR_35) |=> creditQ == CR_35); // R7

  AST_PAID_MATCH: assert property (@(posedge clk) disable iff (strobes.clr)
    paidQ == (creditQ == CR_35)); // R9

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (strobes.clr)
    creditQ <= CR_35); // R10

endmodule

// File: rtl/coin_credit_fsm.sv
module coin_credit_fsm
  import coin_credit_pkg::*;
(
  input  logic                clk,
  input  logic                clearReq,
  input  logic                dimeIn,
  input  logic                quarterIn,
  output logic [CREDIT_W-1:0] creditCode,
  output logic                paid
);

  coinStrobe_t strobes;
  credit_e     creditQ;

  coin_credit_ctrl u_ctrl (
    .clearReq  (clearReq),
    .dimeIn    (dimeIn),
    .quarterIn (quarterIn),
    .strobes   (strobes)
  );

  coin_credit_path u_path (
    .clk     (clk),
    .strobes (strobes),
    .creditQ (creditQ),
    .paidQ   (paid)
  );

  assign creditCode = creditQ;

  AST_QUARTER_OVER_DIME: assert property (@(posedge clk) disable iff (clearReq)
    (dimeIn && quarterIn && creditCode == 3'd0) |=> creditCode == 3'd3); // R8

endmodule

// File: tb/test_coin_credit_fsm.sv
module test_coin_credit_fsm;

  logic       clk = 1'b0;
  logic       clearReq = 1'b1;
  logic       dimeIn = 1'b0;
  logic       quarterIn = 1'b0;
  logic [2:0] creditCode;
  logic       paid;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coin_credit_fsm i_coin_credit_fsm (
    .clk        (clk),
    .clearReq   (clearReq),
    .dimeIn     (dimeIn),
    .quarterIn  (quarterIn),
    .creditCode (creditCode),
    .paid       (paid)
  );

  // Row: {clear, dime, quarter, expected code[2:0], expected paid}
  localparam int NVEC = 24;
  localparam logic [6:0] VEC [NVEC] = '{
    {3'b010, 3'd1, 1'b0},   // 0 -> 10
    {3'b000, 3'd1, 1'b0},   // idle hold
    {3'b001, 3'd5, 1'b1},   // 10 -> 35 by quarter
    {3'b010, 3'd5, 1'b1},   // 35 ignores dime
    {3'b001, 3'd5, 1'b1},   // 35 ignores quarter
    {3'b000, 3'd5, 1'b1},   // 35 holds idle
    {3'b100, 3'd0, 1'b0},   // clear from 35
    {3'b001, 3'd3, 1'b0},   // 0 -> 25
    {3'b010, 3'd5, 1'b1},   // 25 -> 35 by dime
    {3'b100, 3'd0, 1'b0},
    {3'b010, 3'd1, 1'b0},
    {3'b010, 3'd2, 1'b0},   // 10 -> 20
    {3'b001, 3'd5, 1'b1},   // 20 -> 35 by quarter
    {3'b100, 3'd0, 1'b0},
    {3'b010, 3'd1, 1'b0},
    {3'b010, 3'd2, 1'b0},
    {3'b010, 3'd4, 1'b0},   // 20 -> 30
    {3'b001, 3'd5, 1'b1},   // 30 -> 35 by quarter
    {3'b111, 3'd0, 1'b0},   // clear with both coins
    {3'b011, 3'd3, 1'b0},   // both from 0: quarter wins
    {3'b100, 3'd0, 1'b0},
    {3'b010, 3'd1, 1'b0},
    {3'b011, 3'd5, 1'b1},   // both from 10: quarter wins
    {3'b000, 3'd5, 1'b1}
  };

  task automatic step(input logic r, input logic d, input logic q);
    @(negedge clk);
    clearReq  = r;
    dimeIn    = d;
    quarterIn = q;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [2:0] expCode, input logic expPaid);
    testsRun++;
    if (creditCode !== expCode || paid !== expPaid) begin
      testsFailed++;
      $display("FAIL %s: credit code %0d paid %0d, expected code %0d paid %0d",
               tag, creditCode, paid, expCode, expPaid);
    end
  endtask

  function automatic int refNext(input int cur, input bit r, input bit d, input bit q);
    if (r) return 0;
    if (q) return (cur == 0) ? 25 : 35;
    if (d) begin
      if (cur == 0)  return 10;
      if (cur == 10) return 20;
      if (cur == 20) return 30;
      return 35;
    end
    return cur;
  endfunction

  function automatic logic [2:0] codeOf(input int v);
    case (v)
      0:       return 3'd0;
      10:      return 3'd1;
      20:      return 3'd2;
      25:      return 3'd3;
      30:      return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  task automatic reach(input int v);
    step(1'b1, 1'b0, 1'b0);
    case (v)
      10: step(1'b0, 1'b1, 1'b0);
      20: begin step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0); end
      25: step(1'b0, 1'b0, 1'b1);
      30: begin
        step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0);
      end
      35: begin step(1'b0, 1'b0, 1'b1); step(1'b0, 1'b1, 1'b0); end
      default: ;
    endcase
  endtask

  initial begin
    #100000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    #1;
    check("R1 reset state", 3'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4]);
      check($sformatf("table row %0d (R1/R2/R3/R4/R5/R6/R7/R8/R9/R10)", i),
            VEC[i][3:1], VEC[i][0]);
    end

    // Every state against every input pattern.
    for (int s = 0; s < 6; s++) begin
      for (int p = 0; p < 5; p++) begin
        int cur;
        int nxt;
        bit r;
        bit d;
        bit q;
        string tag;
        cur = (s == 0) ? 0 : (s == 1) ? 10 : (s == 2) ? 20 :
              (s == 3) ? 25 : (s == 4) ? 30 : 35;
        r = (p == 4);
        d = (p == 1) || (p == 3) || (p == 4);
        q = (p == 2) || (p == 3) || (p == 4);
        reach(cur);
        check("R10 reach", codeOf(cur), cur == 35);
        step(r, d, q);
        nxt = refNext(cur, r, d, q);
        if (r)                tag = "R1";
        else if (!d && !q)    tag = "R2";
        else if (d && q)      tag = "R8";
        else if (cur == 0)    tag = "R3";
        else if (cur == 10)   tag = "R4";
        else if (cur == 20)   tag = "R5";
        else if (cur == 35)   tag = "R7";
        else                  tag = "R6";
        check($sformatf("%s from %0d pattern %0d (R9 paid)", tag, cur, p),
              codeOf(nxt), nxt == 35);
      end
    end

    // Clear in consecutive cycles while coins keep arriving.
    reach(30);
    step(1'b1, 1'b0, 1'b1);
    check("R1 clear with quarter", 3'd0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R1 back-to-back clear", 3'd0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check("R2 idle after clear", 3'd0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule